// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block divides a 16-bit processor address space into four windows of 16 KB. Each window is served by one backing source: the system ROM, the extension ROM, a plug-in cartridge, one of four user RAM banks, or a window into video RAM. Software picks the source of each window by writing one page-control I/O port. The block decodes every processor access into one chip select, a bank number and a 14-bit offset. It also gates the write enable so that stores to ROM are dropped.

The lowest and highest windows each choose from their own table of four sources, and the two tables differ. One choice in the lowest window's table reaches user RAM bank 3, which is the bank the highest window also uses. The two middle windows each choose between their own RAM bank and the video RAM window. A second group of four I/O ports holds two separate 2-bit video bank numbers. One places the 16 KB video RAM window that the processor sees. The other names the bank that the display fetches from. The memories and the cartridge are outside the block.

Top module: `page_mapper`

## Requirements
- R1: `offset` always equals `cpu_addr[13:0]`, and `cpu_addr[15:14]` selects the page (0 lowest, 3 highest).
- R2: A cycle with `rst` high clears the page-control register and both video bank registers. After reset, page 0 maps the system ROM, page 3 the cartridge, pages 1 and 2 the video window, and both video banks read 0.
- R3: Page 3 is decoded from control bits 7:6 as follows: 0 selects the cartridge, 1 the system ROM, 2 user RAM bank 3 and 3 the extension ROM.
- R4: Page 0 is decoded from control bits 4:3 as follows: 0 selects the system ROM, 1 the cartridge, 2 user RAM bank 0 and 3 user RAM bank 3.
- R5: Page 1 maps user RAM bank 1 when control bit 2 is 1, and the video window when it is 0.
- R6: Page 2 maps user RAM bank 2 when control bit 5 is 1, and the video window when it is 0.
- R7: `mem_we` is high only when `cpu_wr` is high and the selected source is RAM, video RAM or the cartridge. It stays low for the system ROM and the extension ROM.
- R8: An I/O write to any port from 0x0C to 0x0F loads `io_data[1:0]` into the processor video bank and `io_data[5:4]` into `disp_bank`. When the video window is selected, `mem_bank` carries the processor video bank. An I/O write to any other port leaves both banks unchanged.
- R9: At most one of `cs_sys`, `cs_cart`, `cs_ext`, `cs_ram` and `cs_vram` is high. All of them are low unless `cpu_rd` or `cpu_wr` is high. `mem_bank` gives the RAM bank when `cs_ram` is high.
- R10: The page-control register is loaded from `io_data` by an I/O write to port `PAGE_PORT` (default 0x02). The new mapping appears on the outputs in the cycle after that write's clock edge, and not before it.
- R11: I/O writes to ports other than `PAGE_PORT` leave the page mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor memory read |
| cpu_wr | input | 1 | Processor memory write |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| cs_sys | output | 1 | System ROM select |
| cs_cart | output | 1 | Cartridge select |
| cs_ext | output | 1 | Extension ROM select |
| cs_ram | output | 1 | User RAM select |
| cs_vram | output | 1 | Video RAM select |
| mem_bank | output | 2 | RAM bank, or processor video bank for video RAM |
| offset | output | 14 | Offset within the selected source |
| mem_we | output | 1 | Write enable to the selected source |
| disp_bank | output | 2 | Video bank used by the display |

## Verification
The selects, the bank, the offset and the write enable are combinational from the address, the strobes and the registered state. Each address vector is therefore sampled at the same negative clock edge where it is driven, after a short settle delay. Port writes take effect at a clock edge. For that reason every mapping or bank check after an I/O write is sampled at the negative edge that follows the capturing edge. One directed test also samples before that edge, to show that the old mapping still holds there.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;

    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 2;
    localparam int OFF_W   = ADDR_W - PAGE_W;
    localparam int NPAGES  = 1 << PAGE_W;
    localparam int BANK_W  = 2;
    localparam int CTRL_W  = 8;

    // control-field positions inside the page-control register
    localparam int TOP_SEL_LSB = 6;
    localparam int LOW_SEL_LSB = 3;
    localparam int P1_RAM_BIT  = 2;
    localparam int P2_RAM_BIT  = 5;

    typedef enum logic [2:0] {
        SRC_SYS  = 3'd0,
        SRC_CART = 3'd1,
        SRC_EXT  = 3'd2,
        SRC_RAM  = 3'd3,
        SRC_VRAM = 3'd4
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [BANK_W-1:0] bank;
    } pmap_t;

    function automatic pmap_t mk(src_e s, logic [BANK_W-1:0] b);
        pmap_t m;
        m.src  = s;
        m.bank = b;
        return m;
    endfunction

    function automatic pmap_t low_page_map(logic [1:0] sel);
        case (sel)
            2'd0:    return mk(SRC_SYS, 2'd0);
            2'd1:    return mk(SRC_CART, 2'd0);
            2'd2:    return mk(SRC_RAM, 2'd0);
            default: return mk(SRC_RAM, 2'd3);
        endcase
    endfunction

    function automatic pmap_t top_page_map(logic [1:0] sel);
        case (sel)
            2'd0:    return mk(SRC_CART, 2'd0);
            2'd1:    return mk(SRC_SYS, 2'd0);
            2'd2:    return mk(SRC_RAM, 2'd3);
            default: return mk(SRC_EXT, 2'd0);
        endcase
    endfunction

    function automatic logic src_writable(src_e s);
        return (s == SRC_RAM) || (s == SRC_VRAM) || (s == SRC_CART);
    endfunction

endpackage

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
    import page_mapper_pkg::*;
#(
    parameter int          PORT_W     = 8,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  PAGE_PORT  = 8'h02,
    parameter logic [7:0]  VBANK_BASE = 8'h0C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_data,
    output logic [CTRL_W-1:0] page_ctrl,
    output logic [BANK_W-1:0] cpu_vbank,
    output logic [BANK_W-1:0] disp_vbank
);
    localparam int VB_SPAN_W = 2;

    logic hit_page, hit_vbank;

    always_comb begin
        hit_page  = io_wr && (io_port == PORT_W'(PAGE_PORT));
        hit_vbank = io_wr && (io_port[PORT_W-1:VB_SPAN_W] ==
                              VBANK_BASE[PORT_W-1:VB_SPAN_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_ctrl  <= '0;
            cpu_vbank  <= '0;
            disp_vbank <= '0;
        end else begin
            if (hit_page)
                page_ctrl <= io_data[CTRL_W-1:0];
            if (hit_vbank) begin
                cpu_vbank  <= io_data[1:0];
                disp_vbank <= io_data[5:4];
            end
        end
    end

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (page_ctrl == '0 && cpu_vbank == '0 && disp_vbank == '0));

    // R10
    page_load_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_port == PORT_W'(PAGE_PORT)) |=> page_ctrl == $past(io_data[CTRL_W-1:0]));

    // R11
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_port == PORT_W'(PAGE_PORT)) |=> $stable(page_ctrl));

    // R8
    vbank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_port[PORT_W-1:2] == VBANK_BASE[PORT_W-1:2])
        |=> ($stable(cpu_vbank) && $stable(disp_vbank)));

endmodule

// File: rtl/pm_page_decode.sv
module pm_page_decode
    import page_mapper_pkg::*;
(
    input  logic [CTRL_W-1:0]       page_ctrl,
    input  logic [BANK_W-1:0]       cpu_vbank,
    output pmap_t [NPAGES-1:0]      maps
);
    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        if (g == 0) begin : g_low
            always_comb maps[g] = low_page_map(page_ctrl[LOW_SEL_LSB +: 2]);
        end else if (g == NPAGES - 1) begin : g_top
            always_comb maps[g] = top_page_map(page_ctrl[TOP_SEL_LSB +: 2]);
        end else begin : g_mid
            localparam int RBIT = (g == 1) ? P1_RAM_BIT : P2_RAM_BIT;
            always_comb begin
                if (page_ctrl[RBIT])
                    maps[g] = mk(SRC_RAM, BANK_W'(g));
                else
                    maps[g] = mk(SRC_VRAM, cpu_vbank);
            end
        end
    end
endmodule

// File: rtl/pm_access_out.sv
module pm_access_out
    import page_mapper_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  pmap_t [NPAGES-1:0]  maps,
    output logic                cs_sys,
    output logic                cs_cart,
    output logic                cs_ext,
    output logic                cs_ram,
    output logic                cs_vram,
    output logic [BANK_W-1:0]   mem_bank,
    output logic [OFF_W-1:0]    offset,
    output logic                mem_we
);
    pmap_t             cur;
    logic              act;
    logic [PAGE_W-1:0] page;

    always_comb begin
        page     = cpu_addr[ADDR_W-1:OFF_W];
        cur      = maps[page];
        act      = cpu_rd || cpu_wr;
        offset   = cpu_addr[OFF_W-1:0];
        cs_sys   = act && (cur.src == SRC_SYS);
        cs_cart  = act && (cur.src == SRC_CART);
        cs_ext   = act && (cur.src == SRC_EXT);
        cs_ram   = act && (cur.src == SRC_RAM);
        cs_vram  = act && (cur.src == SRC_VRAM);
        mem_bank = (cur.src == SRC_RAM || cur.src == SRC_VRAM) ? cur.bank : '0;
        mem_we   = cpu_wr && src_writable(cur.src);
    end

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_sys, cs_cart, cs_ext, cs_ram, cs_vram}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd || cpu_wr) |-> !(cs_sys || cs_cart || cs_ext || cs_ram || cs_vram));

    // R7
    rom_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cpu_wr && !cs_sys && !cs_ext));

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import page_mapper_pkg::*;
#(
    parameter logic [7:0] PAGE_PORT  = 8'h02,
    parameter logic [7:0] VBANK_BASE = 8'h0C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic        io_wr,
    input  logic [7:0]  io_port,
    input  logic [7:0]  io_data,
    output logic        cs_sys,
    output logic        cs_cart,
    output logic        cs_ext,
    output logic        cs_ram,
    output logic        cs_vram,
    output logic [1:0]  mem_bank,
    output logic [13:0] offset,
    output logic        mem_we,
    output logic [1:0]  disp_bank
);
    logic [CTRL_W-1:0]  page_ctrl;
    logic [BANK_W-1:0]  cpu_vbank;
    pmap_t [NPAGES-1:0] maps;

    pm_ctrl_regs #(
        .PORT_W(8), .DATA_W(8), .PAGE_PORT(PAGE_PORT), .VBANK_BASE(VBANK_BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .page_ctrl(page_ctrl), .cpu_vbank(cpu_vbank), .disp_vbank(disp_bank)
    );

    pm_page_decode u_dec (
        .page_ctrl(page_ctrl), .cpu_vbank(cpu_vbank), .maps(maps)
    );

    pm_access_out u_out (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .maps(maps), .cs_sys(cs_sys), .cs_cart(cs_cart), .cs_ext(cs_ext),
        .cs_ram(cs_ram), .cs_vram(cs_vram), .mem_bank(mem_bank),
        .offset(offset), .mem_we(mem_we)
    );

    // R8
    vram_bank_chk: assert property (@(posedge clk) disable iff (rst)
        cs_vram |-> mem_bank == cpu_vbank);

endmodule

// File: tb/page_mapper_test.sv
module page_mapper_test;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] addr;
        logic        wr;
        logic [4:0]  sel;   // {sys, cart, ext, ram, vram}
        logic [1:0]  bank;
        logic        we;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h0000, 1'b0, 5'b10000, 2'd0, 1'b0},  // R4 sys
        '{8'h00, 16'h0123, 1'b1, 5'b10000, 2'd0, 1'b0},  // R7 sys no write
        '{8'h08, 16'h0010, 1'b1, 5'b01000, 2'd0, 1'b1},  // R4 cart
        '{8'h10, 16'h3FFF, 1'b1, 5'b00010, 2'd0, 1'b1},  // R4 ram0
        '{8'h18, 16'h0004, 1'b0, 5'b00010, 2'd3, 1'b0},  // R4 ram3 alias
        '{8'h00, 16'hC000, 1'b0, 5'b01000, 2'd0, 1'b0},  // R3 cart
        '{8'h40, 16'hC001, 1'b1, 5'b10000, 2'd0, 1'b0},  // R3 sys
        '{8'h80, 16'hFFFF, 1'b1, 5'b00010, 2'd3, 1'b1},  // R3 ram3
        '{8'hC0, 16'hE000, 1'b1, 5'b00100, 2'd0, 1'b0},  // R3 ext
        '{8'h00, 16'h4000, 1'b1, 5'b00001, 2'd1, 1'b1},  // R5 vram
        '{8'h04, 16'h4000, 1'b0, 5'b00010, 2'd1, 1'b0},  // R5 ram1
        '{8'h20, 16'h8000, 1'b1, 5'b00010, 2'd2, 1'b1},  // R6 ram2
        '{8'h04, 16'h8001, 1'b0, 5'b00001, 2'd1, 1'b0},  // R6 vram
        '{8'h20, 16'h7FFF, 1'b0, 5'b00001, 2'd1, 1'b0}   // R5 vram
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic io_wr = 1'b0;
    logic [7:0] io_port = '0, io_data = '0;
    logic cs_sys, cs_cart, cs_ext, cs_ram, cs_vram, mem_we;
    logic [1:0] mem_bank, disp_bank;
    logic [13:0] offset;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .cs_sys(cs_sys), .cs_cart(cs_cart), .cs_ext(cs_ext), .cs_ram(cs_ram),
        .cs_vram(cs_vram), .mem_bank(mem_bank), .offset(offset), .mem_we(mem_we),
        .disp_bank(disp_bank)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(logic [7:0] p, logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = p; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(logic [15:0] a, logic w);
        cpu_addr = a; cpu_wr = w; cpu_rd = !w;
        #1;
    endtask

    function automatic logic [4:0] sels();
        return {cs_sys, cs_cart, cs_ext, cs_ram, cs_vram};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        access(16'h0000, 1'b0);
        check("R2 page0", sels(), 5'b10000);
        access(16'hC000, 1'b0);
        check("R2 page3", sels(), 5'b01000);
        access(16'h4000, 1'b0);
        check("R2 page1", {sels(), mem_bank}, {5'b00001, 2'd0});
        check("R2 disp", disp_bank, 2'd0);

        // R8 banks: cpu 1, display 2
        io_write(8'h0D, 8'h21);
        check("R8 disp", disp_bank, 2'd2);

        for (int i = 0; i < NV; i++) begin
            io_write(8'h02, VECS[i].ctrl);
            access(VECS[i].addr, VECS[i].wr);
            check("R3/R4/R5/R6 sel", sels(), VECS[i].sel);
            check("R9 bank", mem_bank, VECS[i].bank);
            check("R7 we", mem_we, VECS[i].we);
            check("R1 offset", offset, VECS[i].addr[13:0]);
        end

        // R9 idle: no select
        cpu_rd = 1'b0; cpu_wr = 1'b0; #1;
        check("R9 idle", {sels(), mem_we}, 6'd0);

        // R10 timing: old map before edge, new after
        io_write(8'h02, 8'h00);
        access(16'hC000, 1'b0);
        @(negedge clk);
        io_wr = 1'b1; io_port = 8'h02; io_data = 8'hC0;
        #1;
        check("R10 before edge", sels(), 5'b01000);
        @(negedge clk);
        io_wr = 1'b0; #1;
        check("R10 after edge", sels(), 5'b00100);

        // R11 other port ignored
        io_write(8'h03, 8'h00);
        access(16'hC000, 1'b0);
        check("R11 ignored", sels(), 5'b00100);

        // R8 other port leaves banks; then a new bank write
        io_write(8'h02, 8'h00);
        io_write(8'h10, 8'hFF);
        access(16'h4000, 1'b1);
        check("R8 ignored cpu", mem_bank, 2'd1);
        check("R8 ignored disp", disp_bank, 2'd2);
        io_write(8'h0E, 8'h30);
        access(16'h8000, 1'b1);
        check("R8 cpu bank", {sels(), mem_bank}, {5'b00001, 2'd0});
        check("R8 disp bank", disp_bank, 2'd3);

        // R2 reset again
        io_write(8'h02, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(16'h0000, 1'b0);
        check("R2 re-reset", sels(), 5'b10000);
        check("R2 re-reset disp", disp_bank, 2'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule